// File: doc/BRIEF.md
# Low-Resolution VGA Scanout Controller

This block produces standard 640x480, 60 Hz VGA raster timing from a 25.175 MHz pixel clock and fills the screen with a small 64x48 image of 3 bits per pixel. The image sits in an external memory as three independent 1-bit color planes (red, green, blue). Each plane stores one source row as consecutive bytes, and the most significant bit of a byte is the leftmost pixel. Every source pixel is enlarged to a 10x10 block of screen pixels.

During each active scan line the controller reads one byte per plane for each 8-pixel group through a synchronous read port. The data returns on the cycle after the request. The byte is staged in a holding register and then shifted out serially, one bit every SCALE pixel clocks. The same source row is fetched again for SCALE consecutive scan lines. Sync pulses are active high. The color outputs are single bits that are forced low outside the visible window; converting them to analog levels is done outside the block.

Top module: `lowres_vga_scanout`

## Requirements
- R1: While `rst_n` is low, `hsync` and `vsync` are 1, and `video_on`, `red`, `grn`, `blu` and `mem_rd_en` are 0.
- R2: Each line starts with `hsync` high for H_SYNC clocks. It is followed by H_BACK back-porch clocks, IMG_W*SCALE active clocks and H_FRONT front-porch clocks. With the defaults these are 96, 48, 640 and 16, for 800 clocks per line.
- R3: Each frame starts with `vsync` high for V_SYNC lines. It is followed by V_BACK, IMG_H*SCALE and V_FRONT lines. With the defaults these are 2, 33, 480 and 10, for 525 lines per frame.
- R4: `video_on` is 1 exactly when the line position and the frame position are both inside their active windows.
- R5: Active column x (0-based) shows image column x/SCALE. Each source bit is therefore held for SCALE clocks. Bit 7 of a byte is the leftmost of its 8 pixels and bit 0 is the rightmost.
- R6: Active line y (0-based) shows source row y/SCALE, so each source row repeats on SCALE consecutive lines.
- R7: `red`, `grn` and `blu` come only from the bytes returned on `mem_rd_red`, `mem_rd_grn` and `mem_rd_blu` respectively.
- R8: `red`, `grn` and `blu` are 0 whenever `video_on` is 0.
- R9: The read strobe obeys these rules:
  - Reads happen only on active lines.
  - The first read, of byte column 0, is issued 3 clocks before the first active clock.
  - Byte column c+1 is read on the first clock of byte column c, for c below IMG_W/8-1.
  - The address is row*(IMG_W/8)+column, and data is taken on the following clock.
- R10: After `rst_n` rises, the raster position starts advancing on the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd_en | output | 1 | Read strobe to the plane memory |
| mem_rd_addr | output | ADDR_W | Byte address shared by all three planes |
| mem_rd_red | input | 8 | Red plane byte, valid the clock after the strobe |
| mem_rd_grn | input | 8 | Green plane byte, valid the clock after the strobe |
| mem_rd_blu | input | 8 | Blue plane byte, valid the clock after the strobe |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| video_on | output | 1 | Visible window flag |
| red | output | 1 | Red pixel |
| grn | output | 1 | Green pixel |
| blu | output | 1 | Blue pixel |

## Verification
A wrong horizontal or vertical count moves `hsync`, `vsync` or `video_on` away from their expected positions within one line or one frame. The per-clock comparison flags such a shift on the first clock where it appears. A staging or shift error inside a byte shows up as a wrong color bit at the first active clock of the affected group. A wrong row counter only appears when a source row boundary is crossed, which happens after SCALE lines. To catch this, every frame is compared against distinct plane patterns, and the read strobe and address are checked on every clock.

// File: rtl/lvs_pkg.sv
package lvs_pkg;

  localparam int NUM_PLANES = 3;
  localparam int BYTE_W     = 8;

  typedef enum logic [1:0] {
    PLANE_R = 2'd0,
    PLANE_G = 2'd1,
    PLANE_B = 2'd2
  } plane_e;

  typedef struct packed {
    logic take;   // capture returned byte into holding register
    logic load;   // move holding register into shifter
    logic shift;  // advance shifter by one bit
  } shift_ctl_t;

endpackage

// File: rtl/lvs_timing.sv
module lvs_timing #(
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int H_ACT   = 640,
  parameter int H_FRONT = 16,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 33,
  parameter int V_ACT   = 480,
  parameter int V_FRONT = 10,
  localparam int H_TOTAL = H_SYNC + H_BACK + H_ACT + H_FRONT,
  localparam int V_TOTAL = V_SYNC + V_BACK + V_ACT + V_FRONT,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_cnt,
  output logic          h_act,
  output logic          v_act,
  output logic          line_end,
  output logic          frame_end,
  output logic          hsync,
  output logic          vsync
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] HS_END = HW'(H_SYNC);
  localparam logic [HW-1:0] HA_BEG = HW'(H_SYNC + H_BACK);
  localparam logic [HW-1:0] HA_END = HW'(H_SYNC + H_BACK + H_ACT);
  localparam logic [VW-1:0] VS_END = VW'(V_SYNC);
  localparam logic [VW-1:0] VA_BEG = VW'(V_SYNC + V_BACK);
  localparam logic [VW-1:0] VA_END = VW'(V_SYNC + V_BACK + V_ACT);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;

  always_comb begin
    h_d = h_q;
    v_d = v_q;
    if (h_q == H_LAST) begin
      h_d = '0;
      v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_d = h_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign h_cnt     = h_q;
  assign h_act     = (h_q >= HA_BEG) && (h_q < HA_END);
  assign v_act     = (v_q >= VA_BEG) && (v_q < VA_END);
  assign line_end  = (h_q == H_LAST);
  assign frame_end = (h_q == H_LAST) && (v_q == V_LAST);
  assign hsync     = (h_q < HS_END);
  assign vsync     = (v_q < VS_END);

endmodule

// File: rtl/lvs_fetch.sv
module lvs_fetch
  import lvs_pkg::*;
#(
  parameter int H_SYNC = 96,
  parameter int H_BACK = 48,
  parameter int IMG_W  = 64,
  parameter int IMG_H  = 48,
  parameter int SCALE  = 10,
  parameter int HW     = 10,
  parameter int ADDR_W = 9,
  localparam int BPR = IMG_W / BYTE_W,
  localparam int DW  = $clog2(SCALE + 1),
  localparam int CW  = $clog2(BPR + 1),
  localparam int RW  = $clog2(IMG_H + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HW-1:0]     h_cnt,
  input  logic              h_act,
  input  logic              v_act,
  input  logic              line_end,
  input  logic              frame_end,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output shift_ctl_t        ctl
);

  localparam logic [HW-1:0] PRE_H    = HW'(H_SYNC + H_BACK - 3);
  localparam logic [HW-1:0] LOAD_H   = HW'(H_SYNC + H_BACK - 1);
  localparam logic [DW-1:0] DOT_LAST = DW'(SCALE - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(BPR - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);

  logic [DW-1:0] dot_q, dot_d;
  logic [2:0]    bit_q, bit_d;
  logic [CW-1:0] col_q, col_d;
  logic [DW-1:0] sub_q, sub_d;
  logic [RW-1:0] row_q, row_d;
  logic          rdv_q;
  logic          pre, byte_start, not_last, byte_end;
  logic [CW-1:0] col_sel;

  // in-line position: pixel within bit, bit within byte, byte column
  always_comb begin
    dot_d = dot_q;
    bit_d = bit_q;
    col_d = col_q;
    if (h_cnt == LOAD_H) begin
      dot_d = '0;
      bit_d = '0;
      col_d = '0;
    end else if (h_act) begin
      if (dot_q == DOT_LAST) begin
        dot_d = '0;
        bit_d = bit_q + 1'b1;
        if (bit_q == 3'd7) col_d = col_q + 1'b1;
      end else begin
        dot_d = dot_q + 1'b1;
      end
    end
  end

  // row repeat: each source row covers SCALE active lines
  always_comb begin
    sub_d = sub_q;
    row_d = row_q;
    if (frame_end) begin
      sub_d = '0;
      row_d = '0;
    end else if (line_end && v_act) begin
      if (sub_q == DOT_LAST) begin
        sub_d = '0;
        row_d = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q <= '0;
      bit_q <= '0;
      col_q <= '0;
      sub_q <= '0;
      row_q <= '0;
      rdv_q <= 1'b0;
    end else begin
      dot_q <= dot_d;
      bit_q <= bit_d;
      col_q <= col_d;
      sub_q <= sub_d;
      row_q <= row_d;
      rdv_q <= rd_en;
    end
  end

  assign pre        = (h_cnt == PRE_H);
  assign byte_start = h_act && (dot_q == '0) && (bit_q == 3'd0);
  assign not_last   = (col_q != COL_LAST);
  assign byte_end   = h_act && (dot_q == DOT_LAST) && (bit_q == 3'd7);
  assign col_sel    = pre ? '0 : col_q + 1'b1;

  assign rd_en   = v_act && (pre || (byte_start && not_last));
  assign rd_addr = ADDR_W'(row_q) * ADDR_W'(BPR) + ADDR_W'(col_sel);

  assign ctl.take  = rdv_q;
  assign ctl.load  = v_act && ((h_cnt == LOAD_H) || (byte_end && not_last));
  assign ctl.shift = h_act && (dot_q == DOT_LAST);

endmodule

// File: rtl/lvs_plane_shifter.sv
module lvs_plane_shifter
  import lvs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  shift_ctl_t        ctl,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              pix
);

  logic [BYTE_W-1:0] hold_q, hold_d;
  logic [BYTE_W-1:0] sh_q, sh_d;

  always_comb begin
    hold_d = ctl.take ? rd_byte : hold_q;
    if (ctl.load)       sh_d = hold_q;
    else if (ctl.shift) sh_d = {sh_q[BYTE_W-2:0], 1'b0};
    else                sh_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
    end
  end

  assign pix = sh_q[BYTE_W-1];

endmodule

// File: rtl/lowres_vga_scanout.sv
module lowres_vga_scanout
  import lvs_pkg::*;
#(
  parameter int H_SYNC  = 96,
  parameter int H_BACK  = 48,
  parameter int H_FRONT = 16,
  parameter int V_SYNC  = 2,
  parameter int V_BACK  = 33,
  parameter int V_FRONT = 10,
  parameter int IMG_W   = 64,
  parameter int IMG_H   = 48,
  parameter int SCALE   = 10,
  localparam int H_ACT   = IMG_W * SCALE,
  localparam int V_ACT   = IMG_H * SCALE,
  localparam int H_TOTAL = H_SYNC + H_BACK + H_ACT + H_FRONT,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int ADDR_W  = $clog2(IMG_H * (IMG_W / 8))
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_red,
  input  logic [7:0]        mem_rd_grn,
  input  logic [7:0]        mem_rd_blu,
  output logic              hsync,
  output logic              vsync,
  output logic              video_on,
  output logic              red,
  output logic              grn,
  output logic              blu
);

  logic rst_s1_q, rst_sync_n;
  logic [HW-1:0] h_cnt;
  logic h_act, v_act, line_end, frame_end;
  shift_ctl_t ctl;
  logic [NUM_PLANES-1:0][BYTE_W-1:0] plane_bytes;
  logic [NUM_PLANES-1:0] plane_pix;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  lvs_timing #(
    .H_SYNC(H_SYNC), .H_BACK(H_BACK), .H_ACT(H_ACT), .H_FRONT(H_FRONT),
    .V_SYNC(V_SYNC), .V_BACK(V_BACK), .V_ACT(V_ACT), .V_FRONT(V_FRONT)
  ) u_timing (
    .clk(clk), .rst_n(rst_sync_n), .h_cnt(h_cnt), .h_act(h_act), .v_act(v_act),
    .line_end(line_end), .frame_end(frame_end), .hsync(hsync), .vsync(vsync)
  );

  lvs_fetch #(
    .H_SYNC(H_SYNC), .H_BACK(H_BACK), .IMG_W(IMG_W), .IMG_H(IMG_H),
    .SCALE(SCALE), .HW(HW), .ADDR_W(ADDR_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_sync_n), .h_cnt(h_cnt), .h_act(h_act), .v_act(v_act),
    .line_end(line_end), .frame_end(frame_end),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .ctl(ctl)
  );

  assign plane_bytes[PLANE_R] = mem_rd_red;
  assign plane_bytes[PLANE_G] = mem_rd_grn;
  assign plane_bytes[PLANE_B] = mem_rd_blu;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    lvs_plane_shifter u_shift (
      .clk(clk), .rst_n(rst_sync_n), .ctl(ctl),
      .rd_byte(plane_bytes[p]), .pix(plane_pix[p])
    );
  end

  assign video_on = h_act && v_act;
  assign red = video_on && plane_pix[PLANE_R];
  assign grn = video_on && plane_pix[PLANE_G];
  assign blu = video_on && plane_pix[PLANE_B];

endmodule

// File: rtl/lvs_checker.sv
module lvs_checker #(
  parameter int H_SYNC = 96,
  parameter int SCALE  = 10
) (
  input logic clk,
  input logic rst_n,
  input logic hsync,
  input logic vsync,
  input logic video_on,
  input logic red,
  input logic grn,
  input logic blu,
  input logic mem_rd_en
);

  logic [15:0] hs_run_q;
  logic [15:0] vo_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_run_q <= '0;
      vo_run_q <= '0;
    end else begin
      hs_run_q <= hsync ? hs_run_q + 16'd1 : 16'd0;
      vo_run_q <= video_on ? vo_run_q + 16'd1 : 16'd0;
    end
  end

  assert_hsync_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync) |-> (hs_run_q == 16'(H_SYNC)));

  assert_window_outside_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    video_on |-> (!hsync && !vsync));

  assert_pixel_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (video_on && ((int'(vo_run_q) % SCALE) != 0)) |-> $stable({red, grn, blu}));

  assert_blank_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !video_on |-> ({red, grn, blu} == 3'b000));

  assert_no_read_in_vsync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !vsync);

endmodule

bind lowres_vga_scanout lvs_checker #(.H_SYNC(H_SYNC), .SCALE(SCALE)) u_lvs_chk (
  .clk(clk), .rst_n(rst_sync_n), .hsync(hsync), .vsync(vsync),
  .video_on(video_on), .red(red), .grn(grn), .blu(blu), .mem_rd_en(mem_rd_en)
);

// File: tb/lowres_vga_scanout_bench.sv
module lowres_vga_scanout_bench;

  // small geometry for whole-frame runs; default geometry on a second instance
  localparam int S_HS = 4, S_HB = 6, S_HF = 3, S_VS = 2, S_VB = 3, S_VF = 2;
  localparam int S_W = 16, S_H = 4, S_SC = 2;
  localparam int S_FRAME = (S_HS + S_HB + S_W*S_SC + S_HF) * (S_VS + S_VB + S_H*S_SC + S_VF);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   total = 0;
  int   bad = 0;
  int   pat_mode = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  logic       s_rd_en, s_hs, s_vs, s_von, s_r, s_g, s_b;
  logic [2:0] s_addr;
  logic [7:0] s_mr, s_mg, s_mb;
  logic       f_rd_en, f_hs, f_vs, f_von, f_r, f_g, f_b;
  logic [8:0] f_addr;
  logic [7:0] f_mr, f_mg, f_mb;

  lowres_vga_scanout #(
    .H_SYNC(S_HS), .H_BACK(S_HB), .H_FRONT(S_HF), .V_SYNC(S_VS), .V_BACK(S_VB),
    .V_FRONT(S_VF), .IMG_W(S_W), .IMG_H(S_H), .SCALE(S_SC)
  ) u_lowres_vga_scanout (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(s_rd_en), .mem_rd_addr(s_addr),
    .mem_rd_red(s_mr), .mem_rd_grn(s_mg), .mem_rd_blu(s_mb),
    .hsync(s_hs), .vsync(s_vs), .video_on(s_von), .red(s_r), .grn(s_g), .blu(s_b)
  );

  lowres_vga_scanout u_lowres_vga_scanout_full (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(f_rd_en), .mem_rd_addr(f_addr),
    .mem_rd_red(f_mr), .mem_rd_grn(f_mg), .mem_rd_blu(f_mb),
    .hsync(f_hs), .vsync(f_vs), .video_on(f_von), .red(f_r), .grn(f_g), .blu(f_b)
  );

  function automatic logic [7:0] pat(int plane, int addr);
    case (pat_mode)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'((addr * 29) + (plane * 71) + 13);
      default: begin
        if (plane == 0)      return 8'hA5 ^ 8'(addr);
        else if (plane == 1) return 8'h3C + 8'(addr);
        else                 return ~8'(addr);
      end
    endcase
  endfunction

  // synchronous-read plane memories
  always @(posedge clk) begin
    if (s_rd_en) begin
      s_mr <= pat(0, int'(s_addr));
      s_mg <= pat(1, int'(s_addr));
      s_mb <= pat(2, int'(s_addr));
    end
    if (f_rd_en) begin
      f_mr <= pat(0, int'(f_addr));
      f_mg <= pat(1, int'(f_addr));
      f_mb <= pat(2, int'(f_addr));
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset_state();
    hold_reset();
    chk("R1", "small hsync", int'(s_hs), 1);
    chk("R1", "small vsync", int'(s_vs), 1);
    chk("R1", "small video_on", int'(s_von), 0);
    chk("R1", "small rgb", int'({s_r, s_g, s_b}), 0);
    chk("R1", "small rd_en", int'(s_rd_en), 0);
    chk("R1", "full hsync", int'(f_hs), 1);
    chk("R1", "full vsync", int'(f_vs), 1);
    chk("R1", "full video_on", int'(f_von), 0);
    chk("R1", "full rgb", int'({f_r, f_g, f_b}), 0);
  endtask

  // reset, release and compare one instance against the raster model each clock
  task automatic run_scan(bit full, int mode, int ncyc);
    int hs, hb, hf, vs, vb, vf, w, sc, ht, vt, ha, va, a0, v0;
    if (full) begin
      hs = 96; hb = 48; hf = 16; vs = 2; vb = 33; vf = 10; w = 64; sc = 10;
    end else begin
      hs = S_HS; hb = S_HB; hf = S_HF; vs = S_VS; vb = S_VB; vf = S_VF; w = S_W; sc = S_SC;
    end
    ha = w * sc;
    va = (full ? 48 : S_H) * sc;
    ht = hs + hb + ha + hf;
    vt = vs + vb + va + vf;
    a0 = hs + hb;
    v0 = vs + vb;
    pat_mode = mode;
    hold_reset();
    rst_n = 1'b1;
    for (int k = 1; k <= ncyc; k++) begin
      int p, h, v, x, y, addr, bpos, col;
      bit von, vact, erd;
      logic [2:0] exp_rgb, act_rgb;
      @(negedge clk);
      p = (k < 2) ? 0 : k - 2;
      h = p % ht;
      v = (p / ht) % vt;
      vact = (v >= v0) && (v < v0 + va);
      von = vact && (h >= a0) && (h < a0 + ha);
      exp_rgb = 3'b000;
      if (von) begin
        x = (h - a0) / sc;
        y = (v - v0) / sc;
        addr = y * (w / 8) + x / 8;
        bpos = 7 - (x % 8);
        exp_rgb = {pat(0, addr)[bpos], pat(1, addr)[bpos], pat(2, addr)[bpos]};
      end
      col = -1;
      if (h == a0 - 3) col = 0;
      else if (h >= a0 && h < a0 + ha && ((h - a0) % (sc * 8)) == 0 && ((h - a0) / (sc * 8)) < (w / 8 - 1))
        col = (h - a0) / (sc * 8) + 1;
      erd = vact && (col >= 0);
      if (full) act_rgb = {f_r, f_g, f_b};
      else      act_rgb = {s_r, s_g, s_b};
      // R2 and R10: sync position counted from the third edge after release
      chk("R2 R10", $sformatf("hsync p=%0d", p), int'(full ? f_hs : s_hs), int'(h < hs));
      chk("R3", $sformatf("vsync p=%0d", p), int'(full ? f_vs : s_vs), int'(v < vs));
      chk("R4", $sformatf("video_on p=%0d", p), int'(full ? f_von : s_von), int'(von));
      if (von)
        chk("R5 R6 R7", $sformatf("rgb x=%0d line=%0d", h - a0, v - v0), int'(act_rgb), int'(exp_rgb));
      else
        chk("R8", $sformatf("rgb blank p=%0d", p), int'(act_rgb), 0);
      chk("R9", $sformatf("rd_en h=%0d v=%0d", h, v), int'(full ? f_rd_en : s_rd_en), int'(erd));
      if (erd)
        chk("R9", $sformatf("rd_addr h=%0d v=%0d", h, v), int'(full ? f_addr : 9'(s_addr)),
            ((v - v0) / sc) * (w / 8) + col);
    end
  endtask

  task automatic test_dark_planes();   run_scan(1'b0, 0, 2 * S_FRAME); endtask
  task automatic test_lit_planes();    run_scan(1'b0, 1, 2 * S_FRAME); endtask
  task automatic test_mixed_planes();  run_scan(1'b0, 2, 3 * S_FRAME); endtask
  task automatic test_midframe_reset();
    run_scan(1'b0, 3, S_FRAME / 2 + 17);
    run_scan(1'b0, 3, 2 * S_FRAME + 5);
  endtask
  task automatic test_default_geometry(); run_scan(1'b1, 2, 36 * 800 + 20); endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    test_reset_state();
    test_dark_planes();
    test_lit_planes();
    test_mixed_planes();
    test_midframe_reset();
    test_default_geometry();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule